// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is a chain of boundary scan cells placed between a core and its device pins. Each cell holds one shift flip-flop and one update latch. A test access port drives four strobes: capture, shift, update and a test-mode select. One serial input and one serial output link the cells into a single scan path. The port controller and the instruction decoding are outside the block.

In a test sequence the controller first captures the values on the parallel inputs into the shift stages. It then clocks the captured results out of the serial output while new test vectors come in at the serial input. Finally it transfers the shifted vector into the update latches. In test mode each parallel output is driven only by its update latch, so shifting never disturbs the tested nodes. In normal mode every cell passes its functional input straight to its output. The whole chain runs on the test clock.

Top module: `bscan_chain`

## Requirements
- R1: While trst_n is low (asynchronous, active low), every shift stage and every update latch is 0 and par_out equals par_in whatever test_mode is; once reset is released in test mode, par_out reads all zeros until the first update.
- R2: With capture_en high at a rising tck edge, shift stage i loads par_in[i] for every i in the same edge. Capture takes priority when shift_en is also high.
- R3: With shift_en high and capture_en low at a rising tck edge, stage CHAIN_LEN-1 loads scan_in and stage i loads stage i+1. scan_out always shows stage 0, so stage 0 leaves the chain first and the first bit shifted in reaches stage 0 after CHAIN_LEN shifts.
- R4: With update_en high, every update latch takes its shift stage value on the falling tck edge. In the default configuration (UPDATE_ON_FALL=1) that edge comes before the next rising edge.
- R5: With neither capture_en nor shift_en high, the shift stages keep their values across rising edges; scan_in is ignored.
- R6: With test_mode high and reset released, par_out[i] is update latch i. With test_mode low, par_out equals par_in.
- R7: The update latches, and so par_out in test mode, do not change while update_en is low, including during capture and shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| capture_en | input | 1 | Load parallel inputs into shift stages |
| shift_en | input | 1 | Move shift stages one cell toward scan_out |
| update_en | input | 1 | Copy shift stages into update latches |
| test_mode | input | 1 | 1: outputs from update latches; 0: functional pass-through |
| scan_in | input | 1 | Serial test data input |
| par_in | input | CHAIN_LEN | Parallel inputs from pins or core |
| par_out | output | CHAIN_LEN | Parallel outputs to pins or core |
| scan_out | output | 1 | Serial test data output (stage 0) |

## Verification
The bench builds the chain with CHAIN_LEN=5 and the default falling-edge update. This makes an exhaustive sweep possible: all 32 capture patterns are each captured, shifted out bit by bit and replaced by a distinct computed vector, then updated. The small length also makes each end of the chain observable within a few cycles. That includes the stage that takes scan_in and the stage that drives scan_out. It also covers capture/shift priority, idle holding and output stability during shifting.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

   typedef enum logic [1:0] {
      SR_HOLD    = 2'd0,
      SR_CAPTURE = 2'd1,
      SR_SHIFT   = 2'd2
   } sr_op_e;

   typedef struct packed {
      sr_op_e op;
      logic   upd;
      logic   tst;
   } bscan_ctl_t;

endpackage

// File: rtl/bscan_ctl.sv
module bscan_ctl
   import bscan_pkg::*;
(
   input  logic       rst_n,
   input  logic       capture_en,
   input  logic       shift_en,
   input  logic       update_en,
   input  logic       test_mode,
   output bscan_ctl_t ctl
);

   always_comb begin
      ctl = '0;
      if (capture_en)    ctl.op = SR_CAPTURE;
      else if (shift_en) ctl.op = SR_SHIFT;
      else               ctl.op = SR_HOLD;
      ctl.upd = update_en;
      // reset forces functional pass-through (R1)
      ctl.tst = test_mode & rst_n;
   end

endmodule

// File: rtl/bscan_cell.sv
module bscan_cell
   import bscan_pkg::*;
#(
   parameter bit UPDATE_ON_FALL = 1'b1
)(
   input  logic       tck,
   input  logic       rst_n,
   input  bscan_ctl_t ctl,
   input  logic       pin_in,
   input  logic       ser_in,
   output logic       sr_q,
   output logic       upd_q,
   output logic       pin_out
);

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= 1'b0;
      end else begin
         unique case (ctl.op)
            SR_CAPTURE: sr_q <= pin_in;
            SR_SHIFT:   sr_q <= ser_in;
            default:    sr_q <= sr_q;
         endcase
      end
   end

   generate
      if (UPDATE_ON_FALL) begin : g_fall
         always_ff @(negedge tck or negedge rst_n) begin
            if (!rst_n)       upd_q <= 1'b0;
            else if (ctl.upd) upd_q <= sr_q;
         end
      end else begin : g_rise
         always_ff @(posedge tck or negedge rst_n) begin
            if (!rst_n)       upd_q <= 1'b0;
            else if (ctl.upd) upd_q <= sr_q;
         end
      end
   endgenerate

   assign pin_out = ctl.tst ? upd_q : pin_in;

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
   import bscan_pkg::*;
#(
   parameter int CHAIN_LEN      = 8,
   parameter bit UPDATE_ON_FALL = 1'b1
)(
   input  logic                 tck,
   input  logic                 trst_n,
   input  logic                 capture_en,
   input  logic                 shift_en,
   input  logic                 update_en,
   input  logic                 test_mode,
   input  logic                 scan_in,
   input  logic [CHAIN_LEN-1:0] par_in,
   output logic [CHAIN_LEN-1:0] par_out,
   output logic                 scan_out
);

   localparam int LAST = CHAIN_LEN - 1;

   generate
      if (CHAIN_LEN < 1) begin : g_len_low
         $error("bscan_chain: CHAIN_LEN must be at least 1");
      end
      if (CHAIN_LEN > 4096) begin : g_len_high
         $error("bscan_chain: CHAIN_LEN must not exceed 4096");
      end
   endgenerate

   bscan_ctl_t           ctl;
   logic [CHAIN_LEN-1:0] sr_vec;
   logic [CHAIN_LEN-1:0] upd_vec;
   logic [CHAIN_LEN-1:0] link;

   bscan_ctl u_ctl (
      .rst_n      (trst_n),
      .capture_en (capture_en),
      .shift_en   (shift_en),
      .update_en  (update_en),
      .test_mode  (test_mode),
      .ctl        (ctl)
   );

   generate
      for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
         if (i == LAST) begin : g_head
            assign link[i] = scan_in;
         end else begin : g_body
            assign link[i] = sr_vec[i+1];
         end

         bscan_cell #(
            .UPDATE_ON_FALL (UPDATE_ON_FALL)
         ) u_cell (
            .tck     (tck),
            .rst_n   (trst_n),
            .ctl     (ctl),
            .pin_in  (par_in[i]),
            .ser_in  (link[i]),
            .sr_q    (sr_vec[i]),
            .upd_q   (upd_vec[i]),
            .pin_out (par_out[i])
         );
      end
   endgenerate

   assign scan_out = sr_vec[0];

   // ---------------- assertions ----------------
   p_reset_clear_r1: assert property (@(posedge tck)
      !trst_n |-> (sr_vec == '0 && upd_vec == '0));

   p_capture_r2: assert property (@(posedge tck) disable iff (!trst_n)
      capture_en |=> sr_vec == $past(par_in));

   generate
      if (CHAIN_LEN > 1) begin : g_sh_chk
         p_shift_r3: assert property (@(posedge tck) disable iff (!trst_n)
            (shift_en && !capture_en) |=>
               sr_vec == {$past(scan_in), $past(sr_vec[LAST:1])});
      end else begin : g_sh_chk1
         p_shift_r3: assert property (@(posedge tck) disable iff (!trst_n)
            (shift_en && !capture_en) |=> sr_vec[0] == $past(scan_in));
      end

      if (UPDATE_ON_FALL) begin : g_upd_chk_fall
         p_update_r4: assert property (@(posedge tck) disable iff (!trst_n)
            update_en |-> upd_vec == sr_vec);
         p_latch_hold_r7: assert property (@(posedge tck) disable iff (!trst_n)
            !update_en |-> $stable(upd_vec));
      end else begin : g_upd_chk_rise
         p_update_r4: assert property (@(posedge tck) disable iff (!trst_n)
            update_en |=> upd_vec == $past(sr_vec));
         p_latch_hold_r7: assert property (@(posedge tck) disable iff (!trst_n)
            !update_en |=> $stable(upd_vec));
      end
   endgenerate

   p_hold_r5: assert property (@(posedge tck) disable iff (!trst_n)
      (!capture_en && !shift_en) |=> $stable(sr_vec));

endmodule

// File: tb/tb_bscan_chain.sv
module tb_bscan_chain;

   localparam int N = 5;

   logic         tck = 1'b0;
   logic         trst_n;
   logic         capture_en = 1'b0;
   logic         shift_en   = 1'b0;
   logic         update_en  = 1'b0;
   logic         test_mode  = 1'b0;
   logic         scan_in    = 1'b0;
   logic [N-1:0] par_in     = '0;
   logic [N-1:0] par_out;
   logic         scan_out;

   int checks   = 0;
   int failures = 0;

   always #10 tck = ~tck;

   bscan_chain #(.CHAIN_LEN(N), .UPDATE_ON_FALL(1'b1)) dut (
      .tck        (tck),
      .trst_n     (trst_n),
      .capture_en (capture_en),
      .shift_en   (shift_en),
      .update_en  (update_en),
      .test_mode  (test_mode),
      .scan_in    (scan_in),
      .par_in     (par_in),
      .par_out    (par_out),
      .scan_out   (scan_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge tck);
      #2;
   endtask

   task automatic idle();
      capture_en = 1'b0; shift_en = 1'b0; update_en = 1'b0;
   endtask

   // shift out CHAIN_LEN bits, checking them against 'exp_out', while feeding 'vin'
   task automatic shift_word(input logic [N-1:0] exp_out, input logic [N-1:0] vin,
                             input logic [N-1:0] hold_out, input string req);
      for (int j = 0; j < N; j++) begin
         chk(req, {31'b0, scan_out}, {31'b0, exp_out[j]});
         scan_in = vin[j]; capture_en = 1'b0; shift_en = 1'b1; update_en = 1'b0;
         tick();
         // R7: shifting leaves par_out on the old latch value
         chk("R7 par_out stable while shifting", {27'b0, par_out}, {27'b0, hold_out});
      end
      idle();
   endtask

   initial begin
      repeat (100000) @(posedge tck);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [N-1:0] latch_model;
      trst_n = 1'b1;
      #1 trst_n = 1'b0;
      test_mode = 1'b1;
      par_in = 5'b10110;
      tick(); tick();
      // R1: pass-through during reset even with test_mode set
      chk("R1 par_out in reset", {27'b0, par_out}, {27'b0, par_in});
      chk("R1 scan_out in reset", {31'b0, scan_out}, 32'd0);
      par_in = 5'b01001;
      #1;
      chk("R1 par_out follows par_in in reset", {27'b0, par_out}, 32'h09);
      @(negedge tck);
      trst_n = 1'b1;
      tick();
      chk("R1 latches clear after reset", {27'b0, par_out}, 32'd0);
      latch_model = '0;

      // Exhaustive sweep of capture patterns
      for (int p = 0; p < (1 << N); p++) begin
         logic [N-1:0] pv;
         logic [N-1:0] qv;
         pv = p[N-1:0];
         qv = N'((p * 7 + 3) % (1 << N));
         test_mode = 1'b1;
         par_in = pv;
         capture_en = 1'b1; tick(); idle();
         chk("R2 capture stage0 on scan_out", {31'b0, scan_out}, {31'b0, pv[0]});
         chk("R7 capture leaves latches", {27'b0, par_out}, {27'b0, latch_model});
         par_in = ~pv;
         shift_word(pv, qv, latch_model, "R3 shifted bit");
         update_en = 1'b1; tick(); idle();
         latch_model = qv;
         chk("R4 latches after update", {27'b0, par_out}, {27'b0, qv});
         chk("R6 test mode drives latches", {27'b0, par_out}, {27'b0, latch_model});
         test_mode = 1'b0;
         #1;
         chk("R6 normal mode pass-through", {27'b0, par_out}, {27'b0, ~pv});
      end

      // R2: capture wins over shift
      test_mode = 1'b1;
      par_in = 5'b10011;
      scan_in = 1'b0;
      capture_en = 1'b1; shift_en = 1'b1; tick(); idle();
      shift_word(5'b10011, 5'b00000, latch_model, "R2 capture priority");

      // R5: idle cycles hold the shift stages, scan_in ignored
      par_in = 5'b01101;
      capture_en = 1'b1; tick(); idle();
      for (int k = 0; k < 4; k++) begin
         scan_in = k[0];
         tick();
         chk("R5 hold stage0", {31'b0, scan_out}, 32'd1);
      end
      shift_word(5'b01101, 5'b11111, latch_model, "R5 held word");

      // R3: a single 1 walks from stage N-1 to scan_out in N shifts
      par_in = '0;
      capture_en = 1'b1; tick(); idle();
      for (int k = 0; k < N; k++) begin
         scan_in = (k == 0);
         shift_en = 1'b1; tick(); idle();
         chk("R3 walking one", {31'b0, scan_out}, {31'b0, (k == N-1)});
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule